// File: doc/BRIEF.md
# Four-Bank Message Store with Conflict Parking

This block holds soft messages for an iterative decoder in four single-port RAM banks. It behaves like a memory with one read and two writes per cycle. The two low address bits pick the bank, and the remaining bits index a word inside that bank. Each cycle the store can read one bank. In the same cycle it can write up to two other banks. One of those writes is the incoming processed message; the other is a message held back from an earlier cycle.

An incoming write may target the bank being read in that cycle. In that case the message goes into a single-entry parking register. The parked message is written to its bank in the first cycle that bank is not being read. Conflicts are found only by comparing the current read and write addresses. A read of the parked address returns the parked value.

If a new conflict arrives while the parking register is occupied and cannot drain, the input is refused: ready goes low and a sticky overflow flag is set.

Top module: `msg_bank_store`

## Requirements
- R1: A read issued with `rd_en` high returns the word at `rd_addr` on `rd_data` at the next rising clock edge. `rd_data` holds its value otherwise and is zero after reset.
- R2: Address bits [1:0] select the bank and bits [AW-1:2] select the word within it. Each of the 2^AW addresses stores an independent word.
- R3: A write whose bank is not being read, and not being drained from the parking register, is stored directly. `wr_ready` is high and the parking register is not used.
- R4: A write whose bank is being read in the same cycle is placed in the parking register (`park_full` high after the edge). While the read keeps hitting that bank, the parked entry stays in place.
- R5: A read of the address held in the parking register returns the parked data.
- R6: A parked entry is written to its bank in the first cycle that bank is not read. If no new entry is parked in that cycle, `park_full` drops after the edge.
- R7: In one cycle the parked entry and a direct write to a different bank both complete. An incoming write to the bank being drained, or to the bank being read, takes the freed parking slot.
- R8: When a write needs the parking register and it is occupied and cannot drain, `wr_ready` is low and the write is discarded. `overflow` is set and stays high until reset.
- R9: After reset, `wr_ready` is high, and `park_full` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data, one cycle after the request |
| wr_en | input | 1 | Write request from the processing path |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_ready | output | 1 | Write accepted this cycle |
| park_full | output | 1 | Parking register occupied |
| overflow | output | 1 | Sticky flag: a write was refused |

## Verification
The bench builds the store with DW=8 and AW=4, which gives four words per bank. With so few words, every bank collides within a few vectors. The sequences cover a park followed by a bypassed read, and a blocked park that forces a refusal. They also cover a drain paired with a direct write, and a drain that hands the slot to a new conflict on the same bank. A refused write to an address that was already written is read back afterwards to show that the old word survived. Reset is applied a second time to show that the overflow flag clears.

// File: rtl/msg_bank_store.sv
module msg_bank_store #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          park_full,
  output logic          overflow
);
  localparam int NB    = 4;
  localparam int IW    = AW - 2;
  localparam int DEPTH = 1 << IW;

  logic [DW-1:0] mem [NB][DEPTH];
  logic [AW-1:0] park_addr;
  logic [DW-1:0] park_data;

  logic [1:0]    rd_bank, wr_bank, pk_bank;
  logic [IW-1:0] rd_idx, wr_idx, pk_idx;
  logic          wr_clash, park_go, dir_ok, buf_free, dir_go, park_ld, rd_hit;

  assign rd_bank  = rd_addr[1:0];
  assign wr_bank  = wr_addr[1:0];
  assign pk_bank  = park_addr[1:0];
  assign rd_idx   = rd_addr[AW-1:2];
  assign wr_idx   = wr_addr[AW-1:2];
  assign pk_idx   = park_addr[AW-1:2];

  assign wr_clash = rd_en && (wr_bank == rd_bank);
  assign park_go  = park_full && !(rd_en && (rd_bank == pk_bank));
  assign dir_ok   = !wr_clash && !(park_go && (wr_bank == pk_bank));
  assign buf_free = !park_full || park_go;
  assign wr_ready = dir_ok || buf_free;
  assign dir_go   = wr_en && dir_ok;
  assign park_ld  = wr_en && !dir_ok && buf_free;
  assign rd_hit   = park_full && (park_addr == rd_addr);

  always_ff @(posedge clk) begin
    if (park_go) mem[pk_bank][pk_idx] <= park_data;
    if (dir_go)  mem[wr_bank][wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data   <= '0;
      park_full <= 1'b0;
      park_addr <= '0;
      park_data <= '0;
      overflow  <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_hit ? park_data : mem[rd_bank][rd_idx];
      if (park_ld) begin
        park_full <= 1'b1;
        park_addr <= wr_addr;
        park_data <= wr_data;
      end else if (park_go) begin
        park_full <= 1'b0;
      end
      if (wr_en && !wr_ready) overflow <= 1'b1;
    end
  end

  // R3 / R7: a direct write never lands on the bank being read
  p_direct_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dir_go |-> !(rd_en && (wr_bank == rd_bank)));

  // R7: the two writes of one cycle go to distinct banks
  p_two_writes_distinct_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_go && park_go) |-> (wr_bank != pk_bank));

  // R4: a parked entry blocked by a read of its bank stays put
  p_park_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (park_full && rd_en && (rd_addr[1:0] == park_addr[1:0]))
      |=> (park_full && $stable(park_addr) && $stable(park_data)));

  // R8: refusal only while the parking register is occupied
  p_stall_needs_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> park_full);

  // R8: overflow is sticky
  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R8: a refused write sets the flag
  p_overflow_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ready) |=> overflow);

  // R1: rd_data is stable when no read is issued
  p_rd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/msg_bank_store_tb.sv
module msg_bank_store_tb_top;
  localparam int DW = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_ready, park_full, overflow;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  msg_bank_store #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .park_full(park_full), .overflow(overflow)
  );

  typedef struct packed {
    logic       re;
    logic [3:0] ra;
    logic       we;
    logic [3:0] wa;
    logic [7:0] wd;
    logic       chk;
    logic [7:0] er;
    logic       ery;
    logic       ef;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t V [NV] = '{
    '{1'b0, 4'h0, 1'b1, 4'h0, 8'hA0, 1'b0, 8'h00, 1'b1, 1'b0},
    '{1'b0, 4'h0, 1'b1, 4'h5, 8'hB5, 1'b0, 8'h00, 1'b1, 1'b0},
    '{1'b0, 4'h0, 1'b1, 4'hA, 8'hC2, 1'b0, 8'h00, 1'b1, 1'b0},
    '{1'b0, 4'h0, 1'b1, 4'hF, 8'hD3, 1'b0, 8'h00, 1'b1, 1'b0},
    '{1'b0, 4'h0, 1'b1, 4'hD, 8'hDD, 1'b0, 8'h00, 1'b1, 1'b0},
    '{1'b1, 4'h0, 1'b1, 4'h1, 8'h11, 1'b1, 8'hA0, 1'b1, 1'b0},
    '{1'b1, 4'h5, 1'b1, 4'h9, 8'h99, 1'b1, 8'hB5, 1'b1, 1'b1},
    '{1'b1, 4'h9, 1'b0, 4'h0, 8'h00, 1'b1, 8'h99, 1'b1, 1'b1},
    '{1'b1, 4'h5, 1'b1, 4'hD, 8'h77, 1'b1, 8'hB5, 1'b0, 1'b1},
    '{1'b1, 4'hA, 1'b1, 4'h6, 8'h66, 1'b1, 8'hC2, 1'b1, 1'b1},
    '{1'b1, 4'h9, 1'b1, 4'h3, 8'h33, 1'b1, 8'h99, 1'b1, 1'b0},
    '{1'b1, 4'h6, 1'b0, 4'h0, 8'h00, 1'b1, 8'h66, 1'b1, 1'b0},
    '{1'b1, 4'h3, 1'b1, 4'h7, 8'hE7, 1'b1, 8'h33, 1'b1, 1'b1},
    '{1'b1, 4'h1, 1'b1, 4'hB, 8'hBB, 1'b1, 8'h11, 1'b1, 1'b1},
    '{1'b1, 4'h7, 1'b0, 4'h0, 8'h00, 1'b1, 8'hE7, 1'b1, 1'b1},
    '{1'b1, 4'hB, 1'b0, 4'h0, 8'h00, 1'b1, 8'hBB, 1'b1, 1'b1},
    '{1'b0, 4'h0, 1'b0, 4'h0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0},
    '{1'b1, 4'hB, 1'b0, 4'h0, 8'h00, 1'b1, 8'hBB, 1'b1, 1'b0},
    '{1'b1, 4'hF, 1'b0, 4'h0, 8'h00, 1'b1, 8'hD3, 1'b1, 1'b0},
    '{1'b1, 4'hD, 1'b0, 4'h0, 8'h00, 1'b1, 8'hDD, 1'b1, 1'b0}
  };

  task automatic check(input string req, input int idx, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s step %0d: actual %h expected %h", req, idx, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R9 rd_data", -1, rd_data, 8'h00);
    check("R9 wr_ready", -1, {7'd0, wr_ready}, 8'h01);
    check("R9 park_full", -1, {7'd0, park_full}, 8'h00);
    check("R9 overflow", -1, {7'd0, overflow}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // Vector walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rd_en = V[i].re; rd_addr = V[i].ra;
      wr_en = V[i].we; wr_addr = V[i].wa; wr_data = V[i].wd;
      #1;
      check("R3/R8 wr_ready", i, {7'd0, wr_ready}, {7'd0, V[i].ery});
      @(posedge clk);
      #1;
      check("R4/R6 park_full", i, {7'd0, park_full}, {7'd0, V[i].ef});
      if (V[i].chk) check("R1/R2/R5 rd_data", i, rd_data, V[i].er);
    end

    // R8: overflow stayed set after the refusal
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    #1;
    check("R8 overflow sticky", NV, {7'd0, overflow}, 8'h01);

    // R1: rd_data holds without a read
    @(posedge clk);
    #1;
    check("R1 rd_data hold", NV + 1, rd_data, 8'hDD);

    // R9/R8: reset clears overflow
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 overflow after reset", NV + 2, {7'd0, overflow}, 8'h00);
    check("R9 park_full after reset", NV + 2, {7'd0, park_full}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule